// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Waveform Output

This block is one capture/compare channel that sits beside a free-running or periodic timer counter. It watches the counter value supplied by the timer base and works in one of two modes. In capture mode it picks one of two external trigger signals, passes it through a two-flop synchronizer, detects the chosen edge, and then records the counter value in its channel register and raises its flag. A second capture that lands while the flag is still set marks an overflow. In compare mode it raises an equality strobe and its flag whenever the counter equals the channel register. At that moment it also latches the synchronized level of the selected trigger input.

A waveform unit drives one output pin. It has eight modes and reacts to two events: the channel's own equality strobe and the period-match strobe that comes from the timer base. This lets the block produce PWM, toggled and one-shot waveforms. A software-facing wrapper writes the channel register and clears the flags through a simple strobe interface.

Top module: `ccu_channel`

## Requirements
- R1: While the reset is asserted, and at the first sample after it is released, `ccr`, `flag`, `ovf`, `scci` and `pwm_out` are all 0. The reset is asynchronous and active-low, and its release is synchronized over two clock edges.
- R2: `trig_sel`=0 selects `trig_a` and `trig_sel`=1 selects `trig_b`. The unselected input has no effect. `cci` shows the selected input as it stood two rising edges earlier.
- R3: `edge_sel` bit 0 enables capture on rising edges and bit 1 enables capture on falling edges. 2'b11 captures on both edges and 2'b00 never captures.
- R4: In capture mode (`cap_mode`=1), a qualifying change on the selected input becomes a capture at the third rising edge after the change. That capture stores the `count` present at that edge into `ccr` and sets `flag`.
- R5: A capture while `flag` is 1 sets `ovf`, unless `flag_clr` is asserted in the same cycle. After that, `ovf` stays 1 until an `ovf_clr` cycle.
- R6: In compare mode (`cap_mode`=0), `eq` is 1 in the same cycle whenever `count` equals `ccr`, and `flag` is 1 after that edge. In capture mode `eq` is 0. `flag_clr` clears `flag` unless the flag is set again in the same cycle.
- R7: At each compare match, `scci` takes the current value of `cci`. Otherwise `scci` holds its value.
- R8: `wr_en` loads `wr_data` into `ccr` at the next edge. A write takes priority over a capture in the same cycle.
- R9: The `out_mode` encodings are applied at the edge after the event. The first named action is taken on `eq` and the second on `period_eq`:
  - 0: output follows `out_bit`
  - 1: set
  - 2: toggle/reset
  - 3: set/reset
  - 4: toggle
  - 5: reset
  - 6: toggle/set
  - 7: reset/set
- R10: When `eq` and `period_eq` occur in the same cycle, the action for `period_eq` wins. In modes 1, 4 and 5, `period_eq` alone leaves the output unchanged.
- R11: The counter runs 0..P with `period_eq` at P, the channel holds P/2, and the mode is set/reset. Under those conditions `pwm_out` is high for exactly P/2 out of every P+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count | input | CNT_W | Counter value from the timer base |
| period_eq | input | 1 | Period-match equality strobe from the timer base |
| trig_a | input | 1 | Trigger source 0 (asynchronous) |
| trig_b | input | 1 | Trigger source 1 (asynchronous) |
| cap_mode | input | 1 | 1 selects capture mode, 0 selects compare mode |
| trig_sel | input | 1 | Trigger source select |
| edge_sel | input | 2 | Capture edge enables (bit0 rising, bit1 falling) |
| out_mode | input | 3 | Waveform mode |
| out_bit | input | 1 | Output level used in mode 0 |
| wr_en | input | 1 | Channel register write strobe |
| wr_data | input | CNT_W | Channel register write data |
| flag_clr | input | 1 | Flag clear strobe |
| ovf_clr | input | 1 | Overflow clear strobe |
| ccr | output | CNT_W | Channel register value |
| flag | output | 1 | Channel flag |
| ovf | output | 1 | Capture overflow bit |
| cci | output | 1 | Synchronized level of the selected input |
| scci | output | 1 | Input level latched at compare match |
| eq | output | 1 | Channel equality strobe |
| pwm_out | output | 1 | Waveform output pin |

## Verification
The assertions check these relations on every cycle:
- a compare match always leaves the flag set;
- capture mode never raises `eq`;
- the overflow bit only appears over a set flag and is sticky until its clear;
- writes land in the register one edge later;
- set/reset mode obeys both of its events.

The bench scenarios cover what needs history and exact timing: the three-edge capture latency through the synchronizer, which trigger and edge are used, the latched `scci` value, every output mode against every compare position including coincidence with the period match, and the exact duty count of the square wave.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [2:0] {
    OM_BIT     = 3'd0,
    OM_SET     = 3'd1,
    OM_TGL_RST = 3'd2,
    OM_SET_RST = 3'd3,
    OM_TGL     = 3'd4,
    OM_RST     = 3'd5,
    OM_TGL_SET = 3'd6,
    OM_RST_SET = 3'd7
  } out_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_e;

  // Action taken on the channel equality event
  function automatic pin_act_e chan_action(out_mode_e m);
    case (m)
      OM_SET, OM_SET_RST:             chan_action = ACT_SET;
      OM_TGL_RST, OM_TGL, OM_TGL_SET: chan_action = ACT_TGL;
      OM_RST, OM_RST_SET:             chan_action = ACT_CLR;
      default:                        chan_action = ACT_HOLD;
    endcase
  endfunction

  // Action taken on the period-match event
  function automatic pin_act_e period_action(out_mode_e m);
    case (m)
      OM_TGL_RST, OM_SET_RST: period_action = ACT_CLR;
      OM_TGL_SET, OM_RST_SET: period_action = ACT_SET;
      default:                period_action = ACT_HOLD;
    endcase
  endfunction

  function automatic logic apply_action(pin_act_e a, logic cur);
    case (a)
      ACT_SET: apply_action = 1'b1;
      ACT_CLR: apply_action = 1'b0;
      ACT_TGL: apply_action = ~cur;
      default: apply_action = cur;
    endcase
  endfunction

endpackage

// File: rtl/ccu_insync.sv
module ccu_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = din;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

endmodule

// File: rtl/ccu_capcmp.sv
module ccu_capcmp #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             cap_mode,
  input  logic             cap_ev,
  input  logic             sel_lvl,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] ccr,
  output logic             flag,
  output logic             ovf,
  output logic             scci,
  output logic             eq
);

  logic [CNT_W-1:0] ccr_q, ccr_d;
  logic             flag_q, flag_d;
  logic             ovf_q, ovf_d;
  logic             scci_q, scci_d;
  logic             match;
  logic             capture;

  assign match   = ~cap_mode & (count == ccr_q);
  assign capture = cap_mode & cap_ev;

  always_comb begin
    ccr_d  = ccr_q;
    flag_d = flag_q;
    ovf_d  = ovf_q;
    scci_d = scci_q;
    if (wr_en)
      ccr_d = wr_data;
    else if (capture)
      ccr_d = count;
    if (capture || match)
      flag_d = 1'b1;
    else if (flag_clr)
      flag_d = 1'b0;
    if (capture && flag_q && !flag_clr)
      ovf_d = 1'b1;
    else if (ovf_clr)
      ovf_d = 1'b0;
    if (match)
      scci_d = sel_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q  <= '0;
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
      scci_q <= 1'b0;
    end else begin
      ccr_q  <= ccr_d;
      flag_q <= flag_d;
      ovf_q  <= ovf_d;
      scci_q <= scci_d;
    end
  end

  assign ccr  = ccr_q;
  assign flag = flag_q;
  assign ovf  = ovf_q;
  assign scci = scci_q;
  assign eq   = match;

endmodule

// File: rtl/ccu_outgen.sv
module ccu_outgen
  import ccu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       out_bit,
  input  logic       ch_eq,
  input  logic       per_eq,
  output logic       pin
);

  logic      pin_q, pin_d, after_ch;
  out_mode_e m;

  assign m = out_mode_e'(mode);

  always_comb begin
    after_ch = ch_eq ? apply_action(chan_action(m), pin_q) : pin_q;
    if (m == OM_BIT)
      pin_d = out_bit;
    else if (per_eq)
      pin_d = apply_action(period_action(m), after_ch);
    else
      pin_d = after_ch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

endmodule

// File: rtl/ccu_channel.sv
module ccu_channel #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             period_eq,
  input  logic             trig_a,
  input  logic             trig_b,
  input  logic             cap_mode,
  input  logic             trig_sel,
  input  logic [1:0]       edge_sel,
  input  logic [2:0]       out_mode,
  input  logic             out_bit,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] ccr,
  output logic             flag,
  output logic             ovf,
  output logic             cci,
  output logic             scci,
  output logic             eq,
  output logic             pwm_out
);

  localparam int NSRC = 2;

  logic [1:0]      rst_pipe;
  logic            srst_n;
  logic [NSRC-1:0] src_raw, src_lvl, src_rise, src_fall;
  logic            sel_rise, sel_fall, cap_ev;

  // Reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  assign src_raw = {trig_b, trig_a};

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      ccu_insync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (srst_n),
        .din   (src_raw[i]),
        .level (src_lvl[i]),
        .rise  (src_rise[i]),
        .fall  (src_fall[i])
      );
    end
  endgenerate

  assign cci      = src_lvl[trig_sel];
  assign sel_rise = src_rise[trig_sel];
  assign sel_fall = src_fall[trig_sel];
  assign cap_ev   = (edge_sel[0] & sel_rise) | (edge_sel[1] & sel_fall);

  ccu_capcmp #(.CNT_W(CNT_W)) u_capcmp (
    .clk      (clk),
    .rst_n    (srst_n),
    .count    (count),
    .cap_mode (cap_mode),
    .cap_ev   (cap_ev),
    .sel_lvl  (cci),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_clr (flag_clr),
    .ovf_clr  (ovf_clr),
    .ccr      (ccr),
    .flag     (flag),
    .ovf      (ovf),
    .scci     (scci),
    .eq       (eq)
  );

  ccu_outgen u_outgen (
    .clk     (clk),
    .rst_n   (srst_n),
    .mode    (out_mode),
    .out_bit (out_bit),
    .ch_eq   (eq),
    .per_eq  (period_eq),
    .pin     (pwm_out)
  );

endmodule

// File: rtl/ccu_channel_chk.sv
module ccu_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eq,
  input logic             flag,
  input logic             cap_mode,
  input logic             ovf,
  input logic             ovf_clr,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] ccr,
  input logic [2:0]       out_mode,
  input logic             period_eq,
  input logic             pwm_out
);

  // R6
  flag_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eq |=> flag);

  // R6
  no_eq_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode |-> !eq);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  // R5
  ovf_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(flag));

  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ccr == $past(wr_data)));

  // R9
  setrst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 3'd3 && eq && !period_eq) |=> pwm_out);

  // R10
  setrst_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 3'd3 && period_eq) |=> !pwm_out);

endmodule

bind ccu_channel ccu_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .eq        (eq),
  .flag      (flag),
  .cap_mode  (cap_mode),
  .ovf       (ovf),
  .ovf_clr   (ovf_clr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ccr       (ccr),
  .out_mode  (out_mode),
  .period_eq (period_eq),
  .pwm_out   (pwm_out)
);

// File: tb/ccu_channel_test.sv
module ccu_channel_test;

  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam int P     = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] count;
  logic             period_eq, trig_a, trig_b, cap_mode, trig_sel;
  logic [1:0]       edge_sel;
  logic [2:0]       out_mode;
  logic             out_bit, wr_en, flag_clr, ovf_clr;
  logic [CNT_W-1:0] wr_data;
  logic [CNT_W-1:0] ccr;
  logic             flag, ovf, cci, scci, eq, pwm_out;

  int tests = 0;
  int fails = 0;
  int bcnt  = 0;
  int hi_cnt;

  // bench model state
  logic [1:0]       m_s1, m_s2, m_s3;
  logic [CNT_W-1:0] m_ccr;
  logic             m_flag, m_ovf, m_scci, m_out;

  always #(CLK_P/2) clk = ~clk;

  ccu_channel #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .count(count), .period_eq(period_eq),
    .trig_a(trig_a), .trig_b(trig_b), .cap_mode(cap_mode), .trig_sel(trig_sel),
    .edge_sel(edge_sel), .out_mode(out_mode), .out_bit(out_bit),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
    .ccr(ccr), .flag(flag), .ovf(ovf), .cci(cci), .scci(scci), .eq(eq),
    .pwm_out(pwm_out)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic compare_all();
    logic exp_eq;
    exp_eq = !cap_mode && (count == m_ccr);
    tests++;
    if (ccr !== m_ccr) begin
      fails++; $display("FAIL R4/R8 ccr: actual=%0d expected=%0d", ccr, m_ccr);
    end
    if (flag !== m_flag) begin
      fails++; $display("FAIL R6/R4 flag: actual=%0b expected=%0b", flag, m_flag);
    end
    if (ovf !== m_ovf) begin
      fails++; $display("FAIL R5 ovf: actual=%0b expected=%0b", ovf, m_ovf);
    end
    if (scci !== m_scci) begin
      fails++; $display("FAIL R7 scci: actual=%0b expected=%0b", scci, m_scci);
    end
    if (pwm_out !== m_out) begin
      fails++; $display("FAIL R9/R10 pwm_out mode %0d: actual=%0b expected=%0b",
                        out_mode, pwm_out, m_out);
    end
    if (cci !== m_s2[trig_sel]) begin
      fails++; $display("FAIL R2 cci: actual=%0b expected=%0b", cci, m_s2[trig_sel]);
    end
    if (eq !== exp_eq) begin
      fails++; $display("FAIL R6 eq: actual=%0b expected=%0b", eq, exp_eq);
    end
  endtask

  // Called at a falling edge with inputs set; advances one clock.
  task automatic tick();
    logic lv, rs, fl, ev, mt, o;
    lv = m_s2[trig_sel];
    rs = m_s2[trig_sel] & ~m_s3[trig_sel];
    fl = ~m_s2[trig_sel] & m_s3[trig_sel];
    ev = cap_mode && ((edge_sel[0] && rs) || (edge_sel[1] && fl));
    mt = !cap_mode && (count == m_ccr);
    o  = m_out;
    if (out_mode == 3'd0) o = out_bit;
    else begin
      if (mt) begin
        if (out_mode == 3'd1 || out_mode == 3'd3) o = 1'b1;
        if (out_mode == 3'd5 || out_mode == 3'd7) o = 1'b0;
        if (out_mode == 3'd2 || out_mode == 3'd4 || out_mode == 3'd6) o = ~o;
      end
      if (period_eq) begin
        if (out_mode == 3'd2 || out_mode == 3'd3) o = 1'b0;
        if (out_mode == 3'd6 || out_mode == 3'd7) o = 1'b1;
      end
    end
    @(posedge clk);
    m_s3 = m_s2;
    m_s2 = m_s1;
    m_s1 = {trig_b, trig_a};
    if (ev && m_flag && !flag_clr) m_ovf = 1'b1;
    else if (ovf_clr)              m_ovf = 1'b0;
    if (ev || mt)      m_flag = 1'b1;
    else if (flag_clr) m_flag = 1'b0;
    if (mt) m_scci = lv;
    if (wr_en)   m_ccr = wr_data;
    else if (ev) m_ccr = count;
    m_out = o;
    @(negedge clk);
    compare_all();
    if (pwm_out) hi_cnt++;
  endtask

  // one counter step in up mode 0..P
  task automatic step_cnt();
    bcnt      = (bcnt == P) ? 0 : bcnt + 1;
    count     = CNT_W'(bcnt);
    period_eq = (bcnt == P);
  endtask

  initial begin
    rst_n = 1'b0; count = '0; period_eq = 1'b0; trig_a = 1'b0; trig_b = 1'b0;
    cap_mode = 1'b1; trig_sel = 1'b0; edge_sel = 2'b00; out_mode = 3'd0;
    out_bit = 1'b0; wr_en = 1'b0; wr_data = '0; flag_clr = 1'b0; ovf_clr = 1'b0;
    m_s1 = '0; m_s2 = '0; m_s3 = '0; m_ccr = '0;
    m_flag = 0; m_ovf = 0; m_scci = 0; m_out = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    tests++;
    if ({ccr, flag, ovf, scci, pwm_out} !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual=%0h/%0b%0b%0b%0b expected=0",
               ccr, flag, ovf, scci, pwm_out);
    end

    // Compare mode: every output mode against several channel values (R6 R7 R9 R10)
    cap_mode = 1'b0;
    for (int md = 0; md < 8; md++) begin
      for (int k = 0; k < 5; k++) begin
        int vals[5] = '{0, 4, 6, P, P + 1};
        out_mode = 3'(md);
        wr_en = 1'b1; wr_data = CNT_W'(vals[k]);
        step_cnt(); tick();
        wr_en = 1'b0;
        for (int c = 0; c < 2 * (P + 1); c++) begin
          flag_clr = (bcnt == 2) || (bcnt == 9);
          out_bit  = ((c / 5) % 2) == 1;
          trig_a   = ((c / 3) % 2) == 1;
          trig_b   = ((c / 4) % 2) == 0;
          trig_sel = md[0];
          step_cnt(); tick();
        end
        flag_clr = 1'b0;
      end
    end

    // R11 square wave: set/reset, channel at P/2
    out_mode = 3'd3; wr_en = 1'b1; wr_data = CNT_W'(P / 2);
    step_cnt(); tick(); wr_en = 1'b0;
    for (int c = 0; c < 2 * (P + 1); c++) begin step_cnt(); tick(); end
    hi_cnt = 0;
    for (int c = 0; c < P + 1; c++) begin step_cnt(); tick(); end
    tests++;
    if (hi_cnt != P / 2) begin
      fails++; $display("FAIL R11 duty: actual=%0d expected=%0d", hi_cnt, P / 2);
    end

    // Capture mode: every source and edge selection (R2 R3 R4 R5 R8)
    cap_mode = 1'b1; out_mode = 3'd0;
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 4; e++) begin
        trig_sel = s[0]; edge_sel = 2'(e);
        for (int c = 0; c < 48; c++) begin
          trig_a   = ((c / 4) % 2) == 1;
          trig_b   = ((c / 5) % 2) == 1;
          flag_clr = (c % 17) == 16;
          ovf_clr  = (c == 30);
          wr_en    = (c == 20) || (c == 41);
          wr_data  = CNT_W'(100 + c);
          step_cnt(); tick();
        end
        wr_en = 1'b0; flag_clr = 1'b1; ovf_clr = 1'b1;
        step_cnt(); tick();
        flag_clr = 1'b0; ovf_clr = 1'b0;
      end
    end

    // R4 latency: a single rising edge on trig_b, count recorded at third edge
    trig_sel = 1'b1; edge_sel = 2'b01; trig_a = 1'b0; trig_b = 1'b0;
    for (int c = 0; c < 4; c++) begin step_cnt(); tick(); end
    trig_b = 1'b1;
    step_cnt(); tick();
    step_cnt(); tick();
    step_cnt(); tick();
    tests++;
    if (ccr !== CNT_W'(bcnt) || flag !== 1'b1) begin
      fails++;
      $display("FAIL R4 latency: actual=%0d/%0b expected=%0d/1", ccr, flag, bcnt);
    end

    summary();
    $finish;
  end

endmodule